// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a small programmable device. A four-wire serial interface (test clock, mode select, data in, data out) plus a synchronous test reset drives a sixteen-state controller. The controller steps a 5-bit instruction register and one of three data paths: a single-bit pass-through stage, a 32-bit identification register, and a boundary register built from one cell per input pad, one per output pad and one per output enable.

The decoded instruction also steers the pads, which are modelled as plain vectors. By default the core drives the pads and sees the pad inputs. Under test instructions, the boundary update latches drive the pads or the core, or every output enable is forced off. Leaving the core-test instruction raises a flag that asks for a system reset. The flag stays set until the system reset input is seen.

Top module: `scan_port`

## Requirements
- R1: The controller samples `tms` on the rising edge of `tck` and follows the sixteen-state test diagram. Five consecutive `tms`-high edges from any state reach the reset state. `trst` high at a rising edge forces the reset state at once.
- R2: In the reset state the active instruction becomes 00001 (identify). A data scan then shifts out the `DEVICE_ID` parameter, least significant bit first, and bit 0 of that value is 1.
- R3: Capture-IR loads 00001 into the instruction shift stage. An instruction scan therefore shifts out 1,0,0,0,0 (LSB first) while the new code is shifted in LSB first.
- R4: The active instruction changes only on the edge that leaves Update-IR, or in the reset state. While a new code is being shifted, the pads keep the behaviour of the old instruction.
- R5: Opcode map and data path: 00000 drive-pads, 00010 sample/preload and 00011 core-test select the boundary register. 00001 selects the identification register. 00101 float-pads, 11111 pass-through and every unassigned code select the single-bit stage.
- R6: The single-bit stage captures 0 and then delays `tdi` by one `tck`, so the n-th bit out equals the (n-1)-th bit in.
- R7: The boundary register is N_IN+2*N_OUT bits long. Bits [N_IN-1:0] capture `pin_in`, the next N_OUT bits capture `core_out`, and the top N_OUT bits capture `core_oe`. The update latches load from the shift stage on the edge that leaves Update-DR, and only while the boundary register is selected.
- R8: Under sample/preload, identify, pass-through and unassigned codes, `pin_out`=`core_out`, `pin_oe`=`core_oe` and `core_in`=`pin_in`.
- R9: Under drive-pads, `pin_out` and `pin_oe` come from the output and enable update latches, while `core_in`=`pin_in`.
- R10: Under float-pads, every bit of `pin_oe` is 0 and `pin_out`=`core_out`.
- R11: Under core-test, `core_in` comes from the input update latches, and the pads are driven from the output and enable update latches.
- R12: `core_reset_req` sets one `tck` after the active instruction stops being core-test, whether that happens at Update-IR or through the reset state. It holds until `sys_rst` is high at a rising `tck` edge, which clears it and takes priority.
- R13: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Drive enable for `tdo` |
| sys_rst | input | 1 | System reset, clears the reset request |
| pin_in | input | N_IN | Values arriving at the input pads |
| core_in | output | N_IN | Input values presented to the core |
| core_out | input | N_OUT | Output values from the core |
| core_oe | input | N_OUT | Output enables from the core |
| pin_out | output | N_OUT | Values sent to the output pads |
| pin_oe | output | N_OUT | Enables sent to the output pads |
| core_reset_req | output | 1 | Core needs a system reset after core-test |

## Verification
The hardest condition to reach is a change of instruction part-way through an instruction scan. The pads must hold the previous mode while the shift stage already holds a different code. The bench loads the drive-pads code, then steps the controller by hand into Shift-IR with `tdi` high. It stops after three of five shift edges and compares the pads against the preloaded latches, then again in Exit1-IR. Only after Update-IR does it expect the normal pad path. Reaching the reset state by five `tms`-high edges is brought about from Pause-DR, a state that exists only inside a data scan.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 5;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_DRIVE_PADS = 5'b00000;
  localparam logic [IR_W-1:0] OP_IDENTIFY   = 5'b00001;
  localparam logic [IR_W-1:0] OP_SNAPSHOT   = 5'b00010;
  localparam logic [IR_W-1:0] OP_CORE_TEST  = 5'b00011;
  localparam logic [IR_W-1:0] OP_FLOAT_PADS = 5'b00101;
  localparam logic [IR_W-1:0] OP_PASS       = 5'b11111;
  localparam logic [IR_W-1:0] IR_CAPTURE    = 5'b00001;

  typedef enum logic [1:0] {PATH_PASS, PATH_ID, PATH_BOUND} dr_path_e;
  typedef enum logic [1:0] {PM_FUNC, PM_DRIVE, PM_FLOAT, PM_CORE} pin_mode_e;

  typedef struct packed {
    dr_path_e  path;
    pin_mode_e mode;
  } op_decode_t;

  function automatic op_decode_t decode_op(input logic [IR_W-1:0] op);
    op_decode_t d;
    case (op)
      OP_DRIVE_PADS: d = '{PATH_BOUND, PM_DRIVE};
      OP_IDENTIFY:   d = '{PATH_ID,    PM_FUNC};
      OP_SNAPSHOT:   d = '{PATH_BOUND, PM_FUNC};
      OP_CORE_TEST:  d = '{PATH_BOUND, PM_CORE};
      OP_FLOAT_PADS: d = '{PATH_PASS,  PM_FLOAT};
      default:       d = '{PATH_PASS,  PM_FUNC};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_e st
);
  tap_state_e nxt;

  always_comb begin
    case (st)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) st <= ST_RESET;
    else      st <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst,
  input  logic            tdi,
  input  tap_state_e      st,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (trst) begin
      ir_sh <= '0;
      ir_q  <= OP_IDENTIFY;
    end else begin
      case (st)
        ST_CAP_IR: ir_sh <= IR_CAPTURE;
        ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_UP_IR:  ir_q  <= ir_sh;
        ST_RESET:  ir_q  <= OP_IDENTIFY;
        default:   ;
      endcase
    end
  end

  assign ir_so = ir_sh[0];
endmodule

// File: rtl/tap_serial_reg.sv
module tap_serial_reg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] CAP_VAL = '0
) (
  input  logic tck,
  input  logic trst,
  input  logic cap_en,
  input  logic sh_en,
  input  logic tdi,
  output logic so
);
  logic [W-1:0] sh;

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck) begin
        if (trst)        sh <= CAP_VAL;
        else if (cap_en) sh <= CAP_VAL;
        else if (sh_en)  sh <= tdi;
      end
    end else begin : g_multi
      always_ff @(posedge tck) begin
        if (trst)        sh <= CAP_VAL;
        else if (cap_en) sh <= CAP_VAL;
        else if (sh_en)  sh <= {tdi, sh[W-1:1]};
      end
    end
  endgenerate

  assign so = sh[0];
endmodule

// File: rtl/tap_bound_reg.sv
module tap_bound_reg #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  localparam int LEN  = N_IN + 2 * N_OUT
) (
  input  logic           tck,
  input  logic           trst,
  input  logic           tdi,
  input  logic           cap_en,
  input  logic           sh_en,
  input  logic           up_en,
  input  logic [LEN-1:0] cap_vec,
  output logic [LEN-1:0] upd_q,
  output logic           so
);
  logic [LEN:0] chain;
  assign chain[LEN] = tdi;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    logic sh_b;
    logic up_b;
    always_ff @(posedge tck) begin
      if (trst) begin
        sh_b <= 1'b0;
        up_b <= 1'b0;
      end else begin
        if (cap_en)     sh_b <= cap_vec[i];
        else if (sh_en) sh_b <= chain[i+1];
        if (up_en)      up_b <= sh_b;
      end
    end
    assign chain[i] = sh_b;
    assign upd_q[i] = up_b;
  end

  assign so = chain[0];
endmodule

// File: rtl/scan_port.sv
module scan_port
  import tap_pkg::*;
#(
  parameter int          N_IN      = 4,
  parameter int          N_OUT     = 4,
  parameter logic [31:0] DEVICE_ID = 32'h1A5C_E0B3
) (
  input  logic             tck,
  input  logic             trst,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  input  logic             sys_rst,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe,
  output logic             core_reset_req
);
  localparam int LEN    = N_IN + 2 * N_OUT;
  localparam int OUT_LO = N_IN;
  localparam int OE_LO  = N_IN + N_OUT;

  tap_state_e      st;
  logic [IR_W-1:0] ir_q;
  logic            ir_so;
  op_decode_t      dec;
  logic            cap_dr, sh_dr, up_dr;
  logic            sel_pass, sel_id, sel_bound;
  logic            pass_so, id_so, bound_so, dr_so;
  logic [LEN-1:0]  upd_q;
  logic            in_core_q;

  tap_fsm u_fsm (.tck(tck), .trst(trst), .tms(tms), .st(st));

  tap_ir u_ir (.tck(tck), .trst(trst), .tdi(tdi), .st(st), .ir_q(ir_q), .ir_so(ir_so));

  assign dec       = decode_op(ir_q);
  assign cap_dr    = (st == ST_CAP_DR);
  assign sh_dr     = (st == ST_SH_DR);
  assign up_dr     = (st == ST_UP_DR);
  assign sel_pass  = (dec.path == PATH_PASS);
  assign sel_id    = (dec.path == PATH_ID);
  assign sel_bound = (dec.path == PATH_BOUND);

  tap_serial_reg #(.W(1), .CAP_VAL(1'b0)) u_pass (
    .tck(tck), .trst(trst), .cap_en(cap_dr & sel_pass), .sh_en(sh_dr & sel_pass),
    .tdi(tdi), .so(pass_so)
  );

  tap_serial_reg #(.W(32), .CAP_VAL(DEVICE_ID)) u_id (
    .tck(tck), .trst(trst), .cap_en(cap_dr & sel_id), .sh_en(sh_dr & sel_id),
    .tdi(tdi), .so(id_so)
  );

  tap_bound_reg #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bound (
    .tck(tck), .trst(trst), .tdi(tdi),
    .cap_en(cap_dr & sel_bound), .sh_en(sh_dr & sel_bound), .up_en(up_dr & sel_bound),
    .cap_vec({core_oe, core_out, pin_in}), .upd_q(upd_q), .so(bound_so)
  );

  always_comb begin
    case (dec.path)
      PATH_ID:    dr_so = id_so;
      PATH_BOUND: dr_so = bound_so;
      default:    dr_so = pass_so;
    endcase
  end

  // pad steering by decoded mode
  always_comb begin
    core_in = pin_in;
    pin_out = core_out;
    pin_oe  = core_oe;
    case (dec.mode)
      PM_DRIVE: begin
        pin_out = upd_q[OUT_LO +: N_OUT];
        pin_oe  = upd_q[OE_LO +: N_OUT];
      end
      PM_FLOAT: pin_oe = '0;
      PM_CORE: begin
        core_in = upd_q[N_IN-1:0];
        pin_out = upd_q[OUT_LO +: N_OUT];
        pin_oe  = upd_q[OE_LO +: N_OUT];
      end
      default: ;
    endcase
  end

  // serial output on the falling edge
  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else if (st == ST_SH_IR) begin
      tdo    <= ir_so;
      tdo_en <= 1'b1;
    end else if (st == ST_SH_DR) begin
      tdo    <= dr_so;
      tdo_en <= 1'b1;
    end else begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end
  end

  // reset request after core-test is left
  always_ff @(posedge tck) begin
    in_core_q <= (ir_q == OP_CORE_TEST);
    if (sys_rst)
      core_reset_req <= 1'b0;
    else if (in_core_q && (ir_q != OP_CORE_TEST))
      core_reset_req <= 1'b1;
  end
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import tap_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  localparam int LEN  = N_IN + 2 * N_OUT
) (
  input logic             tck,
  input logic             trst,
  input logic             tms,
  input logic             sys_rst,
  input tap_state_e       st,
  input logic [IR_W-1:0]  ir_q,
  input logic             tdo_en,
  input logic [LEN-1:0]   upd_q,
  input logic [N_IN-1:0]  core_in,
  input logic [N_OUT-1:0] pin_oe,
  input logic             core_reset_req
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck) begin
    if (trst)              ones_cnt <= '0;
    else if (!tms)         ones_cnt <= '0;
    else if (ones_cnt < 5) ones_cnt <= ones_cnt + 3'd1;
  end

  // R1
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (trst)
    (ones_cnt == 3'd5) |-> (st == ST_RESET));

  // R4
  ir_hold_chk: assert property (@(posedge tck) disable iff (trst)
    !(st == ST_UP_IR || st == ST_RESET) |=> $stable(ir_q));

  // R9
  drive_pads_chk: assert property (@(posedge tck) disable iff (trst)
    (ir_q == OP_DRIVE_PADS) |-> (pin_oe == upd_q[N_IN+N_OUT +: N_OUT]));

  // R10
  float_pads_chk: assert property (@(posedge tck) disable iff (trst)
    (ir_q == OP_FLOAT_PADS) |-> (pin_oe == '0));

  // R11
  core_drive_chk: assert property (@(posedge tck) disable iff (trst)
    (ir_q == OP_CORE_TEST) |-> (core_in == upd_q[N_IN-1:0]));

  // R12
  req_hold_chk: assert property (@(posedge tck) disable iff (trst)
    (core_reset_req && !sys_rst) |=> core_reset_req);

  // R12
  req_clear_chk: assert property (@(posedge tck) disable iff (trst)
    sys_rst |=> !core_reset_req);

  // R13
  tdo_en_shift_chk: assert property (@(posedge tck) disable iff (trst)
    tdo_en |-> (st == ST_SH_IR || st == ST_SH_DR));
endmodule

bind scan_port scan_port_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .tck(tck), .trst(trst), .tms(tms), .sys_rst(sys_rst), .st(st), .ir_q(ir_q),
  .tdo_en(tdo_en), .upd_q(upd_q), .core_in(core_in), .pin_oe(pin_oe),
  .core_reset_req(core_reset_req)
);

// File: tb/scan_port_bench.sv
`timescale 1ns/1ps
module scan_port_bench;
  localparam int          NI  = 4;
  localparam int          NO  = 4;
  localparam int          L   = NI + 2 * NO;
  localparam logic [31:0] BID = 32'h2D71_9A45;

  localparam logic [NI-1:0] PI  = 4'b1010;
  localparam logic [NO-1:0] CO  = 4'b0110;
  localparam logic [NO-1:0] COE = 4'b1101;
  localparam logic [L-1:0]  PRE = 12'b0011_1001_0101;
  localparam logic [L-1:0]  CAPV = {COE, CO, PI};
  localparam logic [63:0]   DPAT = 64'h0000_0001_6C3A_95E7;

  // {opcode, path(0 pass,1 id,2 boundary), mode(0 func,1 drive,2 float,3 core)}
  localparam logic [8:0] VECS [0:7] = '{
    {5'b00010, 2'd2, 2'd0},
    {5'b00000, 2'd2, 2'd1},
    {5'b00001, 2'd1, 2'd0},
    {5'b00011, 2'd2, 2'd3},
    {5'b00101, 2'd0, 2'd2},
    {5'b11111, 2'd0, 2'd0},
    {5'b00100, 2'd0, 2'd0},
    {5'b10110, 2'd0, 2'd0}
  };

  logic tck = 1'b0, trst = 1'b1, tms = 1'b0, tdi = 1'b0, sys_rst = 1'b1;
  logic tdo, tdo_en, core_reset_req;
  logic [NI-1:0] pin_in = PI, core_in;
  logic [NO-1:0] core_out = CO, core_oe = COE, pin_out, pin_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  scan_port #(.N_IN(NI), .N_OUT(NO), .DEVICE_ID(BID)) u_scan_port (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .sys_rst(sys_rst), .pin_in(pin_in), .core_in(core_in), .core_out(core_out),
    .core_oe(core_oe), .pin_out(pin_out), .pin_oe(pin_oe),
    .core_reset_req(core_reset_req)
  );

  always #10 tck = ~tck;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic d);
    @(negedge tck); #2;
    tms = t; tdi = d;
    @(posedge tck); #1;
  endtask

  // from Run-Test/Idle, full scan of n bits, back to Run-Test/Idle
  task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                      output logic [63:0] dout, output bit en_ok);
    step(1, 0);
    if (is_ir) step(1, 0);
    step(0, 0);
    step(0, 0);
    dout = '0;
    en_ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #2;
      dout[i] = tdo;
      if (tdo_en !== 1'b1) en_ok = 0;
      tms = (i == n - 1);
      tdi = din[i];
      @(posedge tck); #1;
    end
    step(1, 0);
    step(0, 0);
  endtask

  task automatic check_pins(input logic [1:0] mode, input string tag);
    logic [NI-1:0] e_cin  = PI;
    logic [NO-1:0] e_pout = CO;
    logic [NO-1:0] e_poe  = COE;
    case (mode)
      2'd1: begin e_pout = PRE[NI +: NO]; e_poe = PRE[NI+NO +: NO]; end
      2'd2: e_poe = '0;
      2'd3: begin
        e_cin = PRE[NI-1:0]; e_pout = PRE[NI +: NO]; e_poe = PRE[NI+NO +: NO];
      end
      default: ;
    endcase
    chk({tag, " core_in"}, 64'(core_in), 64'(e_cin));
    chk({tag, " pin_out"}, 64'(pin_out), 64'(e_pout));
    chk({tag, " pin_oe"},  64'(pin_oe),  64'(e_poe));
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] so;
    bit en;
    string tg;

    // reset state
    repeat (3) @(posedge tck);
    @(negedge tck); #2;
    chk("R13 tdo_en in reset", 64'(tdo_en), 64'd0);
    chk("R12 req after sys_rst", 64'(core_reset_req), 64'd0);
    check_pins(2'd0, "R8 reset");
    trst = 0; sys_rst = 0;
    @(posedge tck); #1;
    step(0, 0);

    // R2: identify selected after reset
    scan(0, 33, DPAT, so, en);
    chk("R2 id after reset", so[31:0], 64'(BID));
    chk("R2 id bit0", 64'(so[0]), 64'd1);
    @(negedge tck); #2;
    chk("R13 tdo_en idle", 64'(tdo_en), 64'd0);

    // preload the update latches
    scan(1, 5, 64'(5'b00010), so, en);
    scan(0, L, 64'(PRE), so, en);
    chk("R7 first capture", so[L-1:0], 64'(CAPV));

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic [4:0] op;
      logic [1:0] path, mode;
      {op, path, mode} = VECS[v];
      scan(1, 5, 64'(op), so, en);
      tg = $sformatf("R3 op %b ir capture", op);
      chk(tg, so[4:0], 64'(5'b00001));
      chk("R13 tdo_en ir shift", 64'(en), 64'd1);
      case (mode)
        2'd1: check_pins(mode, $sformatf("R9 op %b", op));
        2'd2: check_pins(mode, $sformatf("R10 op %b", op));
        2'd3: check_pins(mode, $sformatf("R11 op %b", op));
        default: check_pins(mode, $sformatf("R8 op %b", op));
      endcase
      if (path == 2'd2) begin
        scan(0, L, 64'(PRE), so, en);
        chk($sformatf("R5 R7 op %b boundary", op), so[L-1:0], 64'(CAPV));
      end else if (path == 2'd1) begin
        scan(0, 33, DPAT, so, en);
        chk($sformatf("R5 op %b id", op), so[31:0], 64'(BID));
      end else begin
        scan(0, 33, DPAT, so, en);
        chk($sformatf("R5 R6 op %b pass", op), so[32:0], {31'd0, DPAT[31:0], 1'b0});
      end
      chk("R13 tdo_en dr shift", 64'(en), 64'd1);
    end

    // R12: set after leaving core-test, holds, cleared by sys_rst
    chk("R12 req set", 64'(core_reset_req), 64'd1);
    repeat (3) step(0, 0);
    chk("R12 req holds", 64'(core_reset_req), 64'd1);
    @(negedge tck); sys_rst = 1;
    @(posedge tck); #1;
    @(negedge tck); sys_rst = 0;
    @(posedge tck); #1;
    chk("R12 req cleared", 64'(core_reset_req), 64'd0);

    // R7: boundary latches untouched while pass-through is selected
    scan(1, 5, 64'(5'b11111), so, en);
    scan(0, L, 64'(~PRE), so, en);
    scan(1, 5, 64'(5'b00000), so, en);
    check_pins(2'd1, "R7 latches kept");

    // R4: pads hold old mode mid instruction scan
    step(1, 0); step(1, 0); step(0, 0); step(0, 1);
    step(0, 1); step(0, 1); step(0, 1);
    check_pins(2'd1, "R4 mid shift");
    step(0, 1); step(1, 1);
    check_pins(2'd1, "R4 exit1");
    step(1, 0); step(0, 0);
    check_pins(2'd0, "R4 after update");

    // R1: five tms-high edges from Pause-DR
    step(1, 0); step(0, 0); step(1, 0); step(0, 0);
    repeat (5) step(1, 0);
    step(0, 0);
    scan(0, 33, DPAT, so, en);
    chk("R1 five ones reset", so[31:0], 64'(BID));

    // R12: sys_rst while still in core-test, then leave through trst
    scan(1, 5, 64'(5'b00011), so, en);
    @(negedge tck); sys_rst = 1;
    @(posedge tck); #1;
    @(negedge tck); sys_rst = 0;
    step(0, 0); step(0, 0);
    chk("R12 no req while core-test", 64'(core_reset_req), 64'd0);
    check_pins(2'd3, "R11 core-test again");
    @(negedge tck); trst = 1;
    @(posedge tck); #1;
    @(negedge tck); trst = 0;
    @(posedge tck); #1;
    step(0, 0);
    chk("R12 req after trst exit", 64'(core_reset_req), 64'd1);
    scan(0, 33, DPAT, so, en);
    chk("R1 trst selects id", so[31:0], 64'(BID));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule